// File: doc/BRIEF.md
# Boolean Pattern Match Engine

This block evaluates a programmable sum-of-products expression over a set of input lines. The expression is built from a chain of identical slices. Each slice selects one input and tests a condition on it: a level, a latched edge, or an edge event that lasts a single cycle. Consecutive slices are ANDed together. A slice flagged as an endpoint closes its product term. All closed terms are ORed into a registered match flag. A companion output pulses for one cycle whenever the flag goes from false to true.

Software programs the slices through a one-register-per-write port. Each write names a slice, a field kind and the data. Writing a slice's source field also discards any edge that slice has latched, which gives a clean way to re-arm a sticky detector. Reset sets every slice to always-false and clears all latched state, so no match is reported until the slices are programmed.

Top module: `pm_match_engine`

## Requirements
- R1: After reset, `match_o` and `match_rise_o` are 0 and stay 0 for any input pattern until the slices are reprogrammed (every slice resets to condition code 6, always false).
- R2: A write with `wr_kind`=0 stores `wr_data` as the slice's source, and the slice then samples input `in_i[source]`.
- R3: Condition code 4 makes a slice true while its input is 1. Code 5 makes it true while its input is 0.
- R4: Codes 1, 2 and 3 latch a rising edge, a falling edge, or either edge on the selected input. The slice is true from the cycle the edge is seen until the latch is cleared. Edges of a kind the code does not name leave the slice false.
- R5: A source write (`wr_kind`=0) to a slice clears its latched edge. When no new edge occurs, the slice is false from the next evaluation on.
- R6: Code 7 makes a slice true only in the cycle where its input differs from its value one cycle earlier.
- R7: A product term is the AND of the slices from the one after the previous endpoint up to and including the next endpoint. The endpoint flag is written with `wr_kind`=2 using `wr_data[0]`, and it resets to 0.
- R8: `match_o` is the OR of all product terms.
- R9: The last slice always closes a term, whatever value is written to its endpoint flag.
- R10: Code 0 makes a slice always true. Code 6 makes it always false. Condition codes are written with `wr_kind`=1, and `wr_kind`=3 writes nothing.
- R11: `match_o` is registered and shows the expression evaluated on the inputs present before the clock edge. `match_rise_o` is high for exactly the one cycle in which `match_o` changes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_i | input | N_IN | Input lines under test |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Field kind: 0 source, 1 condition, 2 endpoint, 3 none |
| wr_slice | input | SLICE_W | Slice addressed by the write |
| wr_data | input | DATA_W | Write data |
| match_o | output | 1 | Registered result of the expression |
| match_rise_o | output | 1 | One-cycle pulse when the match becomes true |

## Verification
The bench checks that a falling-edge latch ignores rising edges and then holds through idle cycles. A latch that re-evaluated the level would drop the match at once. It re-writes a source with the same value and expects the match to fall. A design that clears only on a source change would keep matching. Event slices are checked to fall back after one cycle, which catches an event wired as sticky. An endpoint written as 0 on the last slice must still close its term. A design that honoured the write would lose that term and never match.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [2:0] {
      PM_TRUE    = 3'd0,
      PM_ST_RISE = 3'd1,
      PM_ST_FALL = 3'd2,
      PM_ST_BOTH = 3'd3,
      PM_HIGH    = 3'd4,
      PM_LOW     = 3'd5,
      PM_FALSE   = 3'd6,
      PM_EVENT   = 3'd7
   } pm_cond_e;

   typedef enum logic [1:0] {
      PM_WR_SRC  = 2'd0,
      PM_WR_COND = 2'd1,
      PM_WR_END  = 2'd2,
      PM_WR_NONE = 2'd3
   } pm_wr_e;
endpackage

// File: rtl/pm_edge_detect.sv
module pm_edge_detect #(
   parameter int N_IN = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] in_i,
   output logic [N_IN-1:0] rise_o,
   output logic [N_IN-1:0] fall_o
);
   logic [N_IN-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= in_i;
   end

   assign rise_o = in_i & ~prev_q;
   assign fall_o = ~in_i & prev_q;

   a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o & fall_o) == '0);
endmodule

// File: rtl/pm_slice.sv
module pm_slice
   import pm_pkg::*;
#(
   parameter int N_IN      = 8,
   parameter int SRC_W     = 3,
   parameter int DATA_W    = 3,
   parameter bit FORCE_END = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_src,
   input  logic              wr_cond,
   input  logic              wr_end,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [N_IN-1:0]   lvl_i,
   input  logic [N_IN-1:0]   rise_i,
   input  logic [N_IN-1:0]   fall_i,
   output logic              val_o,
   output logic              end_o
);
   logic [SRC_W-1:0] src_q;
   pm_cond_e         cond_q;
   logic             end_q;
   logic             sticky_q;
   logic             sel_lvl, sel_rise, sel_fall, catch_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         cond_q <= PM_FALSE;
         end_q  <= 1'b0;
      end else begin
         if (wr_src)  src_q  <= wr_data[SRC_W-1:0];
         if (wr_cond) cond_q <= pm_cond_e'(wr_data[2:0]);
         if (wr_end)  end_q  <= wr_data[0];
      end
   end

   assign sel_lvl  = lvl_i[src_q];
   assign sel_rise = rise_i[src_q];
   assign sel_fall = fall_i[src_q];

   always_comb begin
      case (cond_q)
         PM_ST_RISE: catch_edge = sel_rise;
         PM_ST_FALL: catch_edge = sel_fall;
         PM_ST_BOTH: catch_edge = sel_rise | sel_fall;
         default:    catch_edge = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      sticky_q <= 1'b0;
      else if (wr_src) sticky_q <= 1'b0;
      else if (catch_edge) sticky_q <= 1'b1;
   end

   always_comb begin
      case (cond_q)
         PM_TRUE:    val_o = 1'b1;
         PM_ST_RISE,
         PM_ST_FALL,
         PM_ST_BOTH: val_o = sticky_q | catch_edge;
         PM_HIGH:    val_o = sel_lvl;
         PM_LOW:     val_o = ~sel_lvl;
         PM_EVENT:   val_o = sel_rise | sel_fall;
         default:    val_o = 1'b0;
      endcase
   end

   generate
      if (FORCE_END) begin : g_last
         assign end_o = 1'b1 | end_q;
      end else begin : g_mid
         assign end_o = end_q;
      end
   endgenerate

   a_r5_src_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_src |=> !sticky_q);
   a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q && !wr_src) |=> sticky_q);
   a_r6_event_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_q == PM_EVENT && $stable(src_q) && val_o) |-> (sel_lvl != $past(sel_lvl)));
endmodule

// File: rtl/pm_combine.sv
module pm_combine #(
   parameter int N_SLICE = 8
) (
   input  logic [N_SLICE-1:0] val_i,
   input  logic [N_SLICE-1:0] end_i,
   output logic               match_o
);
   logic acc;

   always_comb begin
      acc     = 1'b1;
      match_o = 1'b0;
      for (int i = 0; i < N_SLICE; i++) begin
         acc = acc & val_i[i];
         if (end_i[i]) begin
            match_o = match_o | acc;
            acc     = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pm_match_engine.sv
module pm_match_engine
   import pm_pkg::*;
#(
   parameter int N_IN    = 8,
   parameter int N_SLICE = 8,
   localparam int SRC_W   = (N_IN > 1) ? $clog2(N_IN) : 1,
   localparam int SLICE_W = (N_SLICE > 1) ? $clog2(N_SLICE) : 1,
   localparam int DATA_W  = (SRC_W > 3) ? SRC_W : 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_IN-1:0]    in_i,
   input  logic               wr_en,
   input  logic [1:0]         wr_kind,
   input  logic [SLICE_W-1:0] wr_slice,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               match_o,
   output logic               match_rise_o
);
   generate
      if (N_IN < 2 || (1 << SRC_W) != N_IN) begin : g_bad_in
         $error("pm_match_engine: N_IN must be a power of two of at least 2");
      end
      if (N_SLICE < 1) begin : g_bad_slice
         $error("pm_match_engine: N_SLICE must be at least 1");
      end
   endgenerate

   logic [N_IN-1:0]    rise, fall;
   logic [N_SLICE-1:0] vals, ends;
   logic               match_d, match_q, rise_q;

   pm_edge_detect #(.N_IN(N_IN)) u_edge (
      .clk(clk), .rst_n(rst_n), .in_i(in_i), .rise_o(rise), .fall_o(fall)
   );

   for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
      logic hit;
      assign hit = wr_en && (wr_slice == SLICE_W'(s));
      pm_slice #(
         .N_IN(N_IN), .SRC_W(SRC_W), .DATA_W(DATA_W),
         .FORCE_END(s == N_SLICE - 1)
      ) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_src  (hit && wr_kind == PM_WR_SRC),
         .wr_cond (hit && wr_kind == PM_WR_COND),
         .wr_end  (hit && wr_kind == PM_WR_END),
         .wr_data (wr_data),
         .lvl_i   (in_i),
         .rise_i  (rise),
         .fall_i  (fall),
         .val_o   (vals[s]),
         .end_o   (ends[s])
      );
   end

   pm_combine #(.N_SLICE(N_SLICE)) u_comb (
      .val_i(vals), .end_i(ends), .match_o(match_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         rise_q  <= 1'b0;
      end else begin
         match_q <= match_d;
         rise_q  <= match_d & ~match_q;
      end
   end

   assign match_o      = match_q;
   assign match_rise_o = rise_q;

   a_r11_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      match_rise_o |-> (match_o && !$past(match_o)));
   a_r11_rise_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (match_d && !match_q) |=> match_rise_o);
   a_r8_no_true_slice: assert property (@(posedge clk) disable iff (!rst_n)
      (vals == '0) |=> !match_o);
   a_r9_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
      ends[N_SLICE-1]);
endmodule

// File: tb/tb_pm_match_engine.sv
module tb_pm_match_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_i = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_kind = '0;
   logic [2:0] wr_slice = '0;
   logic [2:0] wr_data = '0;
   logic       match_o, match_rise_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   typedef struct {
      logic  m;
      logic  r;
      string req;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   pm_match_engine dut (
      .clk(clk), .rst_n(rst_n), .in_i(in_i), .wr_en(wr_en),
      .wr_kind(wr_kind), .wr_slice(wr_slice), .wr_data(wr_data),
      .match_o(match_o), .match_rise_o(match_rise_o)
   );

   // monitor: compares the item queued before each rising edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (match_o !== e.m || match_rise_o !== e.r) begin
            errors++;
            $display("FAIL %s: match=%b rise=%b expected match=%b rise=%b",
                     e.req, match_o, match_rise_o, e.m, e.r);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         checks++;
         $display("FAIL R11 watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic expect_out(input logic m, input logic r, input string req);
      exp_t e;
      e.m = m; e.r = r; e.req = req;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] kind, input int slice, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = kind; wr_slice = 3'(slice); wr_data = 3'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      in_i = '0; rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1: idle after reset, any inputs
      expect_out(1'b0, 1'b0, "R1 reset");
      in_i = 8'hFF;
      expect_out(1'b0, 1'b0, "R1 inputs high");
      in_i = 8'h00;
      expect_out(1'b0, 1'b0, "R1 inputs low");
      wr(2'd3, 0, 4);  // R10: kind 3 writes nothing
      in_i = 8'h01;
      expect_out(1'b0, 1'b0, "R10 kind3 ignored");

      // R3/R7: AND of in1 high and in2 low
      do_reset();
      wr(2'd0, 0, 1); wr(2'd1, 0, 4);
      wr(2'd0, 1, 2); wr(2'd1, 1, 5); wr(2'd2, 1, 1);
      expect_out(1'b0, 1'b0, "R7 one literal false");
      in_i[1] = 1'b1;
      expect_out(1'b1, 1'b1, "R7 term true");
      expect_out(1'b1, 1'b0, "R11 rise one cycle");
      in_i[2] = 1'b1;
      expect_out(1'b0, 1'b0, "R3 low literal fails");
      in_i[2] = 1'b0;
      expect_out(1'b1, 1'b1, "R3 low literal passes");

      // R8/R2: two single-slice terms on in0 and in4
      do_reset();
      wr(2'd0, 0, 0); wr(2'd1, 0, 4); wr(2'd2, 0, 1);
      wr(2'd0, 1, 4); wr(2'd1, 1, 4); wr(2'd2, 1, 1);
      in_i[3] = 1'b1;
      expect_out(1'b0, 1'b0, "R2 unselected input");
      in_i[4] = 1'b1;
      expect_out(1'b1, 1'b1, "R8 second term");
      in_i[4] = 1'b0; in_i[0] = 1'b1;
      expect_out(1'b1, 1'b0, "R8 first term");
      in_i[0] = 1'b0;
      expect_out(1'b0, 1'b0, "R8 no term");

      // R4/R5: sticky falling edge on in3
      do_reset();
      wr(2'd0, 0, 3); wr(2'd1, 0, 2); wr(2'd2, 0, 1);
      in_i[3] = 1'b1;
      expect_out(1'b0, 1'b0, "R4 rising ignored");
      in_i[3] = 1'b0;
      expect_out(1'b1, 1'b1, "R4 falling caught");
      expect_out(1'b1, 1'b0, "R4 held");
      expect_out(1'b1, 1'b0, "R4 still held");
      wr(2'd0, 0, 3);
      expect_out(1'b0, 1'b0, "R5 source write clears");
      expect_out(1'b0, 1'b0, "R5 stays clear");

      // R4: either-edge latch on in2
      do_reset();
      wr(2'd0, 0, 2); wr(2'd1, 0, 3); wr(2'd2, 0, 1);
      in_i[2] = 1'b1;
      expect_out(1'b1, 1'b1, "R4 both rising");
      expect_out(1'b1, 1'b0, "R4 both held");

      // R6: event on in7
      do_reset();
      wr(2'd0, 0, 7); wr(2'd1, 0, 7); wr(2'd2, 0, 1);
      in_i[7] = 1'b1;
      expect_out(1'b1, 1'b1, "R6 event rise");
      expect_out(1'b0, 1'b0, "R6 event gone");
      in_i[7] = 1'b0;
      expect_out(1'b1, 1'b1, "R6 event fall");
      expect_out(1'b0, 1'b0, "R6 event gone again");

      // R9/R10: last slice endpoint forced, slice 7 always true
      do_reset();
      wr(2'd2, 5, 1);
      wr(2'd0, 6, 5); wr(2'd1, 6, 4);
      wr(2'd1, 7, 0); wr(2'd2, 7, 0);
      expect_out(1'b0, 1'b0, "R10 false slices block");
      in_i[5] = 1'b1;
      expect_out(1'b1, 1'b1, "R9 last slice closes term");
      in_i[5] = 1'b0;
      expect_out(1'b0, 1'b0, "R10 true slice alone");

      @(negedge clk);
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R11 scoreboard: pending=%0d expected=0", sb.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule